// File: doc/BRIEF.md
# SPI Pin Timing Skew Adjuster

This block sits between an SPI shift engine and the device pins. It shifts the timing of the serial lines by whole system-clock cycles, so that board and pad delays can be compensated at high serial rates. The outgoing data line is held back by a programmed number of cycles. The incoming data line passes through its own short delay line. The instant at which the incoming bit is captured can be moved up to two cycles ahead of the nominal sampling strobe, or one cycle behind it.

The engine drives a single-cycle nominal sample strobe once per serial bit and reports when it is idle. The block returns the captured bit together with a one-cycle valid pulse. Three 2-bit settings choose the output delay, the input delay and the capture offset. They are copied into working registers only while the engine is idle, so a setting cannot change partway through a word. The block does not choose delay values on its own; they come from outside.

Top module: `spi_io_skew`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mosi_pin`, `rx_bit` and `rx_valid` are 0.
- R2: `mosi_pin` in cycle n equals `mosi_core` from cycle n-1-D, where D (0 to 3) is the output-delay code `cfg_out_dly`.
- R3: The input-delay code `cfg_in_dly` (0 to 3) makes the captured bit an extra 0 to 3 cycles older. With code I and capture code C, a strobe in cycle S captures the `miso_pin` value from cycle S+C-2-I.
- R4: The capture code `cfg_capture` maps 0 to two cycles ahead, 1 to one cycle ahead, 2 to nominal and 3 to one cycle late. For a strobe in cycle S, `rx_valid` is high in cycle S+C+1.
- R5: Each nominal strobe yields exactly one `rx_valid` pulse of one cycle, for every combination of settings.
- R6: `rx_bit` keeps its value in every cycle in which `rx_valid` is low.
- R7: The three settings are copied into the working registers only on clock edges where `eng_idle` is 1. Changes made while `eng_idle` is 0 have no effect on timing until the engine is idle again.
- R8: The input-delay and capture settings act independently. Any pair of codes gives the timing of R3 and R4 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_idle | input | 1 | Shift engine idle; settings are loaded while high |
| strobe_in | input | 1 | Nominal sample strobe, one cycle per serial bit |
| miso_pin | input | 1 | Raw serial input from the pin |
| mosi_core | input | 1 | Serial output bit from the shift engine |
| cfg_out_dly | input | 2 | Output delay code, 0 to 3 cycles |
| cfg_in_dly | input | 2 | Input delay code, 0 to 3 cycles |
| cfg_capture | input | 2 | Capture offset code: 0 is -2, 1 is -1, 2 is nominal, 3 is +1 |
| mosi_pin | output | 1 | Delayed serial output to the pin |
| rx_bit | output | 1 | Captured serial input bit |
| rx_valid | output | 1 | One-cycle pulse when `rx_bit` is updated |

## Verification
The hardest case to reach from the ports is an early capture. There the bit that must be taken was on the input line before the strobe that asks for it arrived. The stimulus therefore drives a single 1 on `miso_pin` in exactly the cycle the settings should select, and 0 in every other cycle. A capture from the wrong tap then reads back as 0. Each table entry pairs a different input delay with a different capture code. A directed case then changes the capture code while the engine is busy and shows that the pulse still arrives at the previously loaded offset.

// File: rtl/spi_skew_pkg.sv
package spi_skew_pkg;
  localparam int CODE_W  = 2;
  localparam int MAX_DLY = (1 << CODE_W) - 1;

  typedef struct packed {
    logic [CODE_W-1:0] out_dly;
    logic [CODE_W-1:0] in_dly;
    logic [CODE_W-1:0] capture;
  } skew_cfg_t;
endpackage

// File: rtl/skew_line.sv
module skew_line #(
  parameter int DEPTH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           d,
  output logic [DEPTH:0] taps
);
  logic [DEPTH:1] stg;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    if (k == 1) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= 1'b0;
        else     stg[k] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= 1'b0;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  // tap k is the input k cycles ago; tap 0 is the live input
  assign taps = {stg, d};
endmodule

// File: rtl/skew_cfg_hold.sv
module skew_cfg_hold
  import spi_skew_pkg::*;
#(
  parameter int NOM_TAP = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      idle,
  input  skew_cfg_t cfg_in,
  output skew_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.out_dly <= '0;
      cfg_q.in_dly  <= '0;
      cfg_q.capture <= CODE_W'(NOM_TAP);
    end else if (idle) begin
      cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/skew_capture.sv
module skew_capture
  import spi_skew_pkg::*;
#(
  parameter int NOM_TAP = 2,
  localparam int DLEN   = NOM_TAP + MAX_DLY,
  localparam int IDX_W  = $clog2(DLEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAX_DLY:0] strb_taps,
  input  logic [DLEN:0]    data_taps,
  input  skew_cfg_t        cfg,
  output logic             rx_bit,
  output logic             rx_valid
);
  logic [IDX_W-1:0] didx;
  logic             fire;
  logic             dsel;

  // the strobe tap picks when to capture; the data tap is fixed at
  // nominal alignment plus the input delay, so early taps read older data
  assign didx = IDX_W'(NOM_TAP) + IDX_W'(cfg.in_dly);
  assign fire = strb_taps[cfg.capture];
  assign dsel = data_taps[didx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= fire;
      if (fire) rx_bit <= dsel;
    end
  end
endmodule

// File: rtl/spi_io_skew.sv
module spi_io_skew
  import spi_skew_pkg::*;
#(
  parameter int NOM_TAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_idle,
  input  logic              strobe_in,
  input  logic              miso_pin,
  input  logic              mosi_core,
  input  logic [CODE_W-1:0] cfg_out_dly,
  input  logic [CODE_W-1:0] cfg_in_dly,
  input  logic [CODE_W-1:0] cfg_capture,
  output logic              mosi_pin,
  output logic              rx_bit,
  output logic              rx_valid
);
  localparam int DLEN = NOM_TAP + MAX_DLY;

  skew_cfg_t          cfg_in;
  skew_cfg_t          cfg_q;
  logic [MAX_DLY:0]   mosi_taps;
  logic [MAX_DLY:0]   strb_taps;
  logic [DLEN:0]      miso_taps;

  assign cfg_in.out_dly = cfg_out_dly;
  assign cfg_in.in_dly  = cfg_in_dly;
  assign cfg_in.capture = cfg_capture;

  skew_cfg_hold #(.NOM_TAP(NOM_TAP)) u_cfg (
    .clk(clk), .rst(rst), .idle(eng_idle), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  skew_line #(.DEPTH(MAX_DLY)) u_mosi_line (
    .clk(clk), .rst(rst), .d(mosi_core), .taps(mosi_taps)
  );

  skew_line #(.DEPTH(MAX_DLY)) u_strb_line (
    .clk(clk), .rst(rst), .d(strobe_in), .taps(strb_taps)
  );

  skew_line #(.DEPTH(DLEN)) u_miso_line (
    .clk(clk), .rst(rst), .d(miso_pin), .taps(miso_taps)
  );

  always_ff @(posedge clk) begin
    if (rst) mosi_pin <= 1'b0;
    else     mosi_pin <= mosi_taps[cfg_q.out_dly];
  end

  skew_capture #(.NOM_TAP(NOM_TAP)) u_cap (
    .clk(clk), .rst(rst), .strb_taps(strb_taps), .data_taps(miso_taps),
    .cfg(cfg_q), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/spi_io_skew_chk.sv
module spi_io_skew_chk
  import spi_skew_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      eng_idle,
  input logic      strobe_in,
  input logic      mosi_core,
  input logic      mosi_pin,
  input logic      rx_bit,
  input logic      rx_valid,
  input skew_cfg_t cfg_q
);
  logic [MAX_DLY:0]  sh;
  logic [CODE_W-1:0] cap_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      cap_p <= '0;
    end else begin
      sh    <= {sh[MAX_DLY-1:0], strobe_in};
      cap_p <= cfg_q.capture;
    end
  end

  // R4
  cap_tap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid == sh[cap_p]);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(eng_idle) |-> $stable(cfg_q));

  // R2
  mosi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.out_dly == '0) |=> (mosi_pin == $past(mosi_core)));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_bit));
endmodule

bind spi_io_skew spi_io_skew_chk u_chk (
  .clk(clk), .rst(rst), .eng_idle(eng_idle), .strobe_in(strobe_in),
  .mosi_core(mosi_core), .mosi_pin(mosi_pin), .rx_bit(rx_bit),
  .rx_valid(rx_valid), .cfg_q(cfg_q)
);

// File: tb/spi_io_skew_tb.sv
module spi_io_skew_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       eng_idle = 1'b1;
  logic       strobe_in = 1'b0;
  logic       miso_pin = 1'b0;
  logic       mosi_core = 1'b0;
  logic [1:0] cfg_out_dly = '0;
  logic [1:0] cfg_in_dly = '0;
  logic [1:0] cfg_capture = 2'd2;
  logic       mosi_pin, rx_bit, rx_valid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  spi_io_skew u_dut (
    .clk(clk), .rst(rst), .eng_idle(eng_idle), .strobe_in(strobe_in),
    .miso_pin(miso_pin), .mosi_core(mosi_core), .cfg_out_dly(cfg_out_dly),
    .cfg_in_dly(cfg_in_dly), .cfg_capture(cfg_capture),
    .mosi_pin(mosi_pin), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  // vectors {out_dly, in_dly, capture}; capture: 0=-2, 1=-1, 2=nominal, 3=+1
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 2'd0, 2'd2}, {2'd1, 2'd0, 2'd0}, {2'd2, 2'd1, 2'd1},
    {2'd3, 2'd2, 2'd3}, {2'd0, 2'd3, 2'd0}, {2'd1, 2'd3, 2'd3},
    {2'd3, 2'd0, 2'd1}, {2'd2, 2'd2, 2'd2}
  };

  function automatic logic pm(int c);
    int h;
    h = c * 1103515245 + 12345;
    return h[16];
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    mosi_core = pm(cyc);
  endtask

  // runs one strobe; checks R2 (mosi), R3/R4/R8 (timing and bit), R5, R6
  task automatic run_case(int od, int id, int cp, int ld_cap);
    int s, vexp, nval, mexp;
    bit seen;
    s = cyc + 6;
    vexp = s + ld_cap + 1;
    nval = 0;
    seen = 0;
    for (int j = 0; j < 14; j++) begin
      tick();
      if (rx_valid) begin
        nval++;
        check("R4 valid cycle", cyc, vexp);
        check("R3 captured bit", rx_bit, 1);
        seen = 1;
      end else if (seen) begin
        check("R6 bit held", rx_bit, 1);
      end
      mexp = pm(cyc - 1 - od);
      check("R2 mosi delay", mosi_pin, mexp);
      strobe_in = (cyc == s);
      miso_pin  = (cyc == s + ld_cap - 2 - id);
    end
    check("R5 one valid", nval, 1);
    if (cp != ld_cap) check("R7 busy change ignored", nval, 1);
  endtask

  task automatic load(int od, int id, int cp);
    cfg_out_dly = 2'(od);
    cfg_in_dly  = 2'(id);
    cfg_capture = 2'(cp);
    eng_idle = 1'b1;
    tick();
    tick();
    eng_idle = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) tick();
    check("R1 reset mosi", mosi_pin, 0);
    check("R1 reset rx_valid", rx_valid, 0);
    check("R1 reset rx_bit", rx_bit, 0);
    rst = 1'b0;
    tick();
    check("R1 after reset rx_valid", rx_valid, 0);
    check("R1 after reset rx_bit", rx_bit, 0);

    // R8: table pairs input delay and capture codes freely
    for (int v = 0; v < 8; v++) begin
      load(int'(VEC[v][5:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]));
      run_case(int'(VEC[v][5:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]),
               int'(VEC[v][1:0]));
    end

    // R7: capture loaded as nominal, then changed to -2 while busy
    load(0, 1, 2);
    cfg_capture = 2'd0;
    cfg_out_dly = 2'd3;
    run_case(0, 1, 0, 2);

    // R7: once idle again the new code takes effect
    load(2, 0, 3);
    run_case(2, 0, 3, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule